// File: doc/BRIEF.md
# Interlocked Four-Phase Word Transfer Link

This block moves a block of data words between two agents that run on unrelated clocks. The sending side (the master) owns the data lines and a ready strobe. The receiving side (the slave) owns an accept strobe. Every change on one strobe is caused by a particular change on the other, so each word crosses in four interlocked phases and neither side ever has to know the other's speed. The master raises ready once a word is stable on the bus. The slave answers ready-high by capturing the word and raising accept. Accept-high makes the master drop ready and clear the bus. Ready-low makes the slave drop accept, and only when the master sees accept low again does it begin the next word.

Each side samples the other side's strobe through its own multi-flop synchroniser before acting on it. On the master side, a start pulse with a nonzero length launches a block, and the source is asked for one word at a time. On the slave side, each received word appears with a one-cycle valid pulse, and a done flag rises after the programmed number of words has completed its handshake.

Top module: `hs_link`

## Requirements
- R1: While reset is applied, and right after it, `busData` is 0 and `dataReady`, `dataAccept`, `rxValid`, `rxDone` and `mBusy` are all low.
- R2: The master holds a word on `busData` for at least one `mClk` cycle before `dataReady` rises, and keeps that word unchanged for as long as `dataReady` stays high. Words go out in source order.
- R3: `dataReady` stays high until the master has seen `dataAccept` high. `dataReady` then falls and, in the same cycle, `busData` returns to 0.
- R4: `dataAccept` rises only while `dataReady` is high, after the slave has seen it through its synchroniser. `dataAccept` falls only after `dataReady` has gone low.
- R5: For the next word, the master raises `dataReady` only when `dataAccept` is low.
- R6: For each captured word, `rxValid` is high for exactly one `sClk` cycle, and `rxData` then equals the word that was sent, in order.
- R7: `txTaken` pulses once for each word the master takes from `txData`. A block of `blkLen` words produces exactly `blkLen` pulses and `blkLen` received words. `mBusy` is high from the start of the block until the last handshake has closed.
- R8: `rxDone` rises once `rxLen` words have completed their handshake. It is low whenever `rxValid` is high, which means it clears on the first capture of the next block.
- R9: A `start` pulse with `blkLen` equal to 0 is ignored: `mBusy` and `dataReady` stay low.
- R10: A `start` pulse while `mBusy` is high is ignored. The running block keeps its length and its word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mClk | input | 1 | Master clock |
| mRst_n | input | 1 | Master asynchronous reset, active low |
| start | input | 1 | One-cycle request to send a block (master domain) |
| blkLen | input | LEN_W | Number of words in the block, sampled at start |
| txData | input | DATA_W | Next word from the source |
| txTaken | output | 1 | One-cycle pulse after the master has latched `txData` |
| mBusy | output | 1 | Master is in the middle of a block |
| sClk | input | 1 | Slave clock |
| sRst_n | input | 1 | Slave asynchronous reset, active low |
| rxLen | input | LEN_W | Expected words per block (slave domain) |
| rxData | output | DATA_W | Last captured word |
| rxValid | output | 1 | One-cycle pulse with each new `rxData` |
| rxDone | output | 1 | Programmed number of words received |
| busData | output | DATA_W | Data lines driven by the master (0 when idle) |
| dataReady | output | 1 | Master strobe: word on the bus |
| dataAccept | output | 1 | Slave strobe: word taken |

## Verification
A master state machine stuck in the wrong phase shows up on the strobes within a few cycles of the far clock. Ready would rise while accept is still high, or it would fall without an accept at all, so the bench compares every edge of each strobe against the level of the other strobe at that moment. A counter that slips shows first at the end of a block, as a pulse count or done flag that does not match the programmed length. A capture taken at the wrong moment shows on the very next `rxValid` as a word out of order or corrupted. The slave clock is switched between slower and faster than the master, so that each synchroniser path is tested with both ratios.

// File: rtl/hs_link_pkg.sv
`timescale 1ns/1ps
package hs_link_pkg;
  // strobes from master control to master datapath
  typedef struct packed {
    logic loadWord;
    logic clearBus;
    logic initCnt;
    logic decCnt;
  } mStrobe_t;

  // strobes from slave control to slave datapath
  typedef struct packed {
    logic capture;
    logic relWord;
  } sStrobe_t;
endpackage

// File: rtl/hs_master_dp.sv
`timescale 1ns/1ps
module hs_master_dp
  import hs_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mStrobe_t          st,
  input  logic [LEN_W-1:0]  blkLen,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] busData,
  output logic              cntZero
);
  logic [LEN_W-1:0] wordsLeft;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busData   <= '0;
      wordsLeft <= '0;
    end else begin
      if (st.loadWord)      busData <= txData;
      else if (st.clearBus) busData <= '0;
      if (st.initCnt)       wordsLeft <= blkLen;
      else if (st.decCnt)   wordsLeft <= wordsLeft - 1'b1;
    end
  end

  assign cntZero = (wordsLeft == '0);

  // R7: the counter never wraps below zero
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    st.decCnt |-> !cntZero);
endmodule

// File: rtl/hs_master_ctrl.sv
`timescale 1ns/1ps
module hs_master_ctrl
  import hs_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     lenValid,
  input  logic     cntZero,
  input  logic     dataAccept,
  output mStrobe_t st,
  output logic     dataReady,
  output logic     txTaken,
  output logic     busy
);
  typedef enum logic [1:0] {M_IDLE, M_SETUP, M_WAIT_ACK, M_WAIT_REL} mState_t;
  mState_t state, nextState;

  logic [SYNC_STAGES-1:0] accPipe;
  logic accS;
  assign accS = accPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accPipe <= '0;
    else        accPipe <= {accPipe[SYNC_STAGES-2:0], dataAccept};
  end

  always_comb begin
    nextState = state;
    st = '0;
    case (state)
      M_IDLE: if (start && lenValid) begin
        st.initCnt  = 1'b1;
        st.loadWord = 1'b1;
        nextState   = M_SETUP;
      end
      M_SETUP: nextState = M_WAIT_ACK;
      M_WAIT_ACK: if (accS) begin
        st.clearBus = 1'b1;
        st.decCnt   = 1'b1;
        nextState   = M_WAIT_REL;
      end
      M_WAIT_REL: if (!accS) begin
        if (cntZero) nextState = M_IDLE;
        else begin
          st.loadWord = 1'b1;
          nextState   = M_SETUP;
        end
      end
      default: nextState = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= M_IDLE;
      dataReady <= 1'b0;
      txTaken   <= 1'b0;
    end else begin
      state     <= nextState;
      dataReady <= (nextState == M_WAIT_ACK);
      txTaken   <= st.loadWord;
    end
  end

  assign busy = (state != M_IDLE);

  // R3: ready is held until accept has been seen
  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dataReady && !accS |=> dataReady);
  // R3: ready only falls after accept was seen high
  a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dataReady) |-> $past(accS));
  // R5: a new word starts only after accept was seen low
  a_r5_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataReady) |-> !$past(accS));
  // R9: zero length start leaves the master idle
  a_r9_zero_len_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == M_IDLE) && !lenValid |=> !dataReady);
endmodule

// File: rtl/hs_slave_dp.sv
`timescale 1ns/1ps
module hs_slave_dp
  import hs_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sStrobe_t          st,
  input  logic [LEN_W-1:0]  rxLen,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxDone
);
  logic [LEN_W-1:0] rxCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData  <= '0;
      rxValid <= 1'b0;
      rxDone  <= 1'b0;
      rxCnt   <= '0;
    end else begin
      rxValid <= st.capture;
      if (st.capture) begin
        rxData <= busData;
        if (rxDone) begin
          rxCnt  <= LEN_W'(1);
          rxDone <= 1'b0;
        end else begin
          rxCnt <= rxCnt + 1'b1;
        end
      end else if (st.relWord && (rxCnt == rxLen)) begin
        rxDone <= 1'b1;
      end
    end
  end

  // R6: valid is a single-cycle pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);
  // R8: done is never high alongside a fresh word
  a_r8_done_low_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> !rxDone);
endmodule

// File: rtl/hs_slave_ctrl.sv
`timescale 1ns/1ps
module hs_slave_ctrl
  import hs_link_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dataReady,
  output sStrobe_t st,
  output logic     dataAccept
);
  typedef enum logic {S_WAIT, S_HOLD} sState_t;
  sState_t state, nextState;

  logic [SYNC_STAGES-1:0] rdyPipe;
  logic rdyS;
  assign rdyS = rdyPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdyPipe <= '0;
    else        rdyPipe <= {rdyPipe[SYNC_STAGES-2:0], dataReady};
  end

  always_comb begin
    nextState = state;
    st = '0;
    case (state)
      S_WAIT: if (rdyS) begin
        st.capture = 1'b1;
        nextState  = S_HOLD;
      end
      S_HOLD: if (!rdyS) begin
        st.relWord = 1'b1;
        nextState  = S_WAIT;
      end
      default: nextState = S_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_WAIT;
      dataAccept <= 1'b0;
    end else begin
      state      <= nextState;
      dataAccept <= (nextState == S_HOLD);
    end
  end

  // R4: accept rises only in answer to a seen ready
  a_r4_accept_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataAccept) |-> $past(rdyS));
  // R4: accept falls only once ready was seen low
  a_r4_drop_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dataAccept) |-> !$past(rdyS));
endmodule

// File: rtl/hs_link.sv
`timescale 1ns/1ps
module hs_link
  import hs_link_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int LEN_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mClk,
  input  logic              mRst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  blkLen,
  input  logic [DATA_W-1:0] txData,
  output logic              txTaken,
  output logic              mBusy,
  input  logic              sClk,
  input  logic              sRst_n,
  input  logic [LEN_W-1:0]  rxLen,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxDone,
  output logic [DATA_W-1:0] busData,
  output logic              dataReady,
  output logic              dataAccept
);
  mStrobe_t mSt;
  sStrobe_t sSt;
  logic     cntZero;

  hs_master_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_mctrl (
    .clk(mClk), .rst_n(mRst_n), .start(start), .lenValid(blkLen != '0),
    .cntZero(cntZero), .dataAccept(dataAccept), .st(mSt),
    .dataReady(dataReady), .txTaken(txTaken), .busy(mBusy));

  hs_master_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_mdp (
    .clk(mClk), .rst_n(mRst_n), .st(mSt), .blkLen(blkLen),
    .txData(txData), .busData(busData), .cntZero(cntZero));

  hs_slave_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_sctrl (
    .clk(sClk), .rst_n(sRst_n), .dataReady(dataReady), .st(sSt),
    .dataAccept(dataAccept));

  hs_slave_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_sdp (
    .clk(sClk), .rst_n(sRst_n), .st(sSt), .rxLen(rxLen),
    .busData(busData), .rxData(rxData), .rxValid(rxValid), .rxDone(rxDone));

  // R2: the word on the bus does not move while ready is high
  a_r2_bus_stable: assert property (@(posedge mClk) disable iff (!mRst_n)
    dataReady && $past(dataReady) |-> $stable(busData));
  // R2: the word was already on the bus the cycle before ready rose
  a_r2_data_first: assert property (@(posedge mClk) disable iff (!mRst_n)
    $rose(dataReady) |-> $stable(busData));
endmodule

// File: tb/hs_link_tb.sv
`timescale 1ns/1ps
module hs_link_tb;
  localparam int DW = 16;
  localparam int LW = 6;

  logic mClk = 0, sClk = 0, mRst_n = 0, sRst_n = 0;
  logic start = 0;
  logic [LW-1:0] blkLen = '0, rxLen = '0;
  logic [DW-1:0] txData = '0;
  logic txTaken, mBusy, rxValid, rxDone, dataReady, dataAccept;
  logic [DW-1:0] rxData, busData;
  realtime sHalf = 5.0;

  always #2 mClk = ~mClk;
  always #(sHalf) sClk = ~sClk;

  hs_link #(.DATA_W(DW), .LEN_W(LW)) u_dut (
    .mClk(mClk), .mRst_n(mRst_n), .start(start), .blkLen(blkLen), .txData(txData),
    .txTaken(txTaken), .mBusy(mBusy), .sClk(sClk), .sRst_n(sRst_n), .rxLen(rxLen),
    .rxData(rxData), .rxValid(rxValid), .rxDone(rxDone), .busData(busData),
    .dataReady(dataReady), .dataAccept(dataAccept));

  int nChecks = 0, nFails = 0, cyc = 0;
  int blk = 0, txIdx = 0, riseIdx = 0, rxIdx = 0, takenCnt = 0;
  bit monOn = 0, firstBlk = 1, finished = 0;

  function automatic logic [DW-1:0] mixWord(int b, int i);
    return DW'((b * 16'h3b1) + (i * 16'h9e3)) ^ DW'(i << 5) ^ 16'h5a5a;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  always @(posedge mClk) begin
    cyc++;
    if (cyc > 150000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // master-side monitor and source model
  logic prevReady = 0;
  logic [DW-1:0] prevBus = '0, heldWord = '0;
  always @(negedge mClk) begin
    if (monOn) begin
      if (dataReady && !prevReady) begin
        check(busData == mixWord(blk, riseIdx), "R2 word order", busData, mixWord(blk, riseIdx));
        check(prevBus == busData, "R2 setup before ready", prevBus, busData);
        check(dataAccept == 1'b0, "R5 accept low at ready rise", dataAccept, 0);
        heldWord = busData;
        riseIdx++;
      end else if (dataReady && prevReady) begin
        check(busData == heldWord, "R2 word held", busData, heldWord);
      end else if (!dataReady && prevReady) begin
        check(busData == '0, "R3 bus cleared", busData, 0);
        check(dataAccept == 1'b1, "R3 ready drops after accept", dataAccept, 1);
      end
      if (txTaken) begin
        takenCnt++;
        txIdx++;
        txData = mixWord(blk, txIdx);
      end
    end
    prevReady = dataReady;
    prevBus   = busData;
  end

  // slave-side monitor
  logic prevAcc = 0, prevValid = 0;
  always @(negedge sClk) begin
    if (monOn) begin
      if (rxValid) begin
        check(rxData == mixWord(blk, rxIdx), "R6 received word", rxData, mixWord(blk, rxIdx));
        check(prevValid == 1'b0, "R6 single-cycle valid", prevValid, 0);
        check(rxDone == 1'b0, "R8 done low with valid", rxDone, 0);
        rxIdx++;
      end
      if (dataAccept && !prevAcc)
        check(dataReady == 1'b1, "R4 accept rises on ready", dataReady, 1);
      if (!dataAccept && prevAcc)
        check(dataReady == 1'b0, "R4 accept falls after ready", dataReady, 0);
    end
    prevAcc   = dataAccept;
    prevValid = rxValid;
  end

  task automatic waitM(int n);
    repeat (n) @(negedge mClk);
  endtask

  task automatic runBlock(int len, bit extraStart);
    blk++;
    txIdx = 0; riseIdx = 0; rxIdx = 0; takenCnt = 0;
    txData = mixWord(blk, 0);
    blkLen = LW'(len);
    rxLen  = LW'(len);
    @(negedge mClk);
    start = 1;
    @(negedge mClk);
    start = 0;
    check(mBusy == 1'b1, "R7 busy after start", mBusy, 1);
    if (extraStart) begin
      waitM(7);
      blkLen = LW'(len + 5);
      start = 1;
      @(negedge mClk);
      start = 0;
      blkLen = LW'(len);
    end
    while (mBusy) @(negedge mClk);
    repeat (3) @(negedge sClk);
    check(takenCnt == len, extraStart ? "R10 words taken" : "R7 words taken", takenCnt, len);
    check(rxIdx == len, extraStart ? "R10 words received" : "R7 words received", rxIdx, len);
    check(riseIdx == len, "R7 ready pulses", riseIdx, len);
    check(rxDone == 1'b1, "R8 done after block", rxDone, 1);
    check(dataReady == 1'b0 && dataAccept == 1'b0, "R7 link idle at end", {dataReady, dataAccept}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    waitM(3);
    // R1 reset values
    check(busData == '0, "R1 bus in reset", busData, 0);
    check({dataReady, dataAccept, rxValid, rxDone, mBusy} == '0, "R1 strobes in reset",
          {dataReady, dataAccept, rxValid, rxDone, mBusy}, 0);
    mRst_n = 1; sRst_n = 1;
    waitM(2);
    check({dataReady, dataAccept, rxValid, rxDone, mBusy} == '0, "R1 strobes after reset",
          {dataReady, dataAccept, rxValid, rxDone, mBusy}, 0);
    monOn = 1;

    // R9 zero-length start
    blkLen = '0;
    @(negedge mClk); start = 1;
    @(negedge mClk); start = 0;
    waitM(10);
    check(mBusy == 1'b0, "R9 busy stays low", mBusy, 0);
    check(dataReady == 1'b0, "R9 ready stays low", dataReady, 0);

    // directed corners: one word with slow slave, full length with fast slave
    sHalf = 5.0;
    runBlock(1, 0);
    sHalf = 1.5;
    runBlock((1 << LW) - 1, 0);

    // random blocks with random slave speed
    for (int k = 0; k < 8; k++) begin
      case ($urandom_range(0, 2))
        0: sHalf = 1.5;
        1: sHalf = 3.5;
        default: sHalf = 9.0;
      endcase
      runBlock($urandom_range(1, 20), 0);
    end

    // R10 start while busy is ignored
    sHalf = 5.0;
    runBlock(6, 1);

    finish_run();
  end
endmodule